// File: doc/BRIEF.md
# Page Hamming ECC Generator

This block computes single-error-correcting Hamming parity over a 512-byte flash page while the bytes pass through a bridge's data path. The page is split into two 256-byte halves, each with its own parity set: 16 line-parity bits that follow the byte index, and 6 column-parity bits that follow the bit position inside a byte. Each half can therefore locate and correct one flipped bit. The whole page yields six ECC bytes.

Software drives the block through an 8-bit mode code. One code clears the accumulators. A second code folds each transferred byte into the parity. A third code turns the 16-bit read port into a result window, which returns the six bytes as three words in an interleaved order. The accumulators are held inverted, so an erased half (all 0xFF) gives all-ones ECC bytes. Error correction itself is done in software.

Top module: `page_ecc_gen`

## Requirements
- R1: After the asynchronous reset is released, `rd_data_o` reads 0x0000 and the block is idle (mode 0x00). Both parity sets are in their cleared state, so a later readout without any data returns 0xFFFF in every word.
- R2: Writing mode 0xF4 clears both parity sets and the byte counter. Byte strobes and read strobes given while the mode is 0xF4, including the dummy read after a clear, are not counted as page bytes.
- R3: Only while the mode is 0xB4 is each `byte_vld_i` byte folded into the parity. Bytes presented in any other mode leave the result unchanged.
- R4: The first 256 bytes after a clear (index 0 to 255) feed set A and the next 256 bytes feed set B. Bytes after the 512th are ignored until the next clear.
- R5: Line parity: for each index bit k (0 to 7) of a byte's position within its half, the XOR of the byte's bits is folded into LP[2k+1] when that index bit is 1 and into LP[2k] when it is 0.
- R6: Column parity: for each bit-position bit k (0 to 2), data bit j is folded into CP[2k+1] when bit k of j is 1 and into CP[2k] when it is 0, across all bytes of the half. A column byte is {CP5..CP0, 2'b11}, with CP in bits 7:2 and bits 1:0 held at 1.
- R7: Reported parity is the inverse of the accumulated XOR. A half of all 0xFF bytes, or of all 0x00 bytes, reports 0xFF in all three of its ECC bytes.
- R8: In mode 0xD4 the read port shows word 0 = {A.LP15..8, A.LP7..0}, word 1 = {B.LP7..0, A column byte} and word 2 = {B column byte, B.LP15..8}, with the upper byte in bits 15:8. In every other mode `rd_data_o` is 0x0000.
- R9: Each `rd_i` in mode 0xD4 moves to the next word in the order 0, 1, 2, 0. Any mode write returns the pointer to word 0.
- R10: A mode write and a byte strobe in the same cycle: the byte is judged under the mode in force before the write, and a clear (0xF4) wins over a byte that is accepted in that cycle. The same priority applies to a read strobe that coincides with a mode write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 8 | Mode code (0xF4 clear, 0xB4 calculate, 0xD4 result) |
| byte_vld_i | input | 1 | A data byte is transferred this cycle |
| byte_i | input | 8 | Data byte |
| rd_i | input | 1 | Read strobe on the data port |
| rd_data_o | output | 16 | Result word at the read pointer |

## Verification
Two functions can act in the same cycle: a mode write and a byte strobe. The bench provokes this in two ways. It writes a clear in the same cycle as a byte in calculate mode, and it writes the calculate code while presenting a non-zero byte. It then reads out the three words. These must equal the erased values, because a counted byte at index 0 would change word 0 to 0xAAAA. The same kind of collision between a read strobe and a mode write is judged by whether the next readout starts again at word 0. A behavioural model is also compared against the read port on every cycle.

// File: rtl/pecc_pkg.sv
package pecc_pkg;
  localparam int BYTE_W  = 8;
  localparam int COL_W   = 3;
  localparam int CP_W    = 2 * COL_W;
  localparam int WORD_W  = 16;
  localparam int NWORDS  = 3;
  localparam int PTR_W   = 2;

  localparam logic [BYTE_W-1:0] MODE_IDLE = 8'h00;
  localparam logic [BYTE_W-1:0] MODE_CLR  = 8'hF4;
  localparam logic [BYTE_W-1:0] MODE_CALC = 8'hB4;
  localparam logic [BYTE_W-1:0] MODE_RES  = 8'hD4;
endpackage

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import pecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_wr_i,
  input  logic [BYTE_W-1:0]     mode_i,
  input  logic                  byte_vld_i,
  input  logic                  rd_i,
  output logic [BYTE_W-1:0]     mode_q_o,
  output logic                  clr_o,
  output logic                  take_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic                  half_o,
  output logic [IDX_W+1:0]      cnt_o,
  output logic [PTR_W-1:0]      ptr_o
);
  localparam int CNT_W = IDX_W + 2;
  localparam logic [CNT_W-1:0] PAGE_LIM = {2'b10, {IDX_W{1'b0}}};

  logic [BYTE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              clr, take, rd_adv;

  assign clr    = mode_wr_i && (mode_i == MODE_CLR);
  // judged under the mode already in force
  assign take   = (mode_q == MODE_CALC) && byte_vld_i && (cnt_q < PAGE_LIM);
  assign rd_adv = (mode_q == MODE_RES) && rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
    end else if (mode_wr_i) begin
      mode_q <= mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (mode_wr_i) begin
      ptr_q <= '0;
    end else if (rd_adv) begin
      ptr_q <= (ptr_q == PTR_W'(NWORDS - 1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  assign mode_q_o = mode_q;
  assign clr_o    = clr;
  assign take_o   = take;
  assign idx_o    = cnt_q[IDX_W-1:0];
  assign half_o   = cnt_q[IDX_W];
  assign cnt_o    = cnt_q;
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import pecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               take_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [BYTE_W-1:0]  data_i,
  output logic [2*IDX_W-1:0] lp_o,
  output logic [CP_W-1:0]    cp_o
);
  localparam int LP_W = 2 * IDX_W;

  logic [LP_W-1:0] lp_q, lp_flip;
  logic [CP_W-1:0] cp_q, cp_flip;
  logic            par;

  always_comb begin
    par     = ^data_i;
    lp_flip = '0;
    for (int k = 0; k < IDX_W; k++) begin
      if (idx_i[k]) lp_flip[2*k+1] = par;
      else          lp_flip[2*k]   = par;
    end
    cp_flip = '0;
    for (int k = 0; k < COL_W; k++) begin
      for (int j = 0; j < BYTE_W; j++) begin
        if (((j >> k) & 1) == 1) cp_flip[2*k+1] = cp_flip[2*k+1] ^ data_i[j];
        else                     cp_flip[2*k]   = cp_flip[2*k]   ^ data_i[j];
      end
    end
  end

  // held inverted: cleared state is all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q <= '1;
      cp_q <= '1;
    end else if (clr_i) begin
      lp_q <= '1;
      cp_q <= '1;
    end else if (take_i) begin
      lp_q <= lp_q ^ lp_flip;
      cp_q <= cp_q ^ cp_flip;
    end
  end

  assign lp_o = lp_q;
  assign cp_o = cp_q;
endmodule

// File: rtl/ecc_result_mux.sv
module ecc_result_mux
  import pecc_pkg::*;
(
  input  logic [15:0]       lp_a_i,
  input  logic [CP_W-1:0]   cp_a_i,
  input  logic [15:0]       lp_b_i,
  input  logic [CP_W-1:0]   cp_b_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              res_en_i,
  output logic [WORD_W-1:0] word_o
);
  logic [BYTE_W-1:0] cb_a, cb_b;

  assign cb_a = {cp_a_i, 2'b11};
  assign cb_b = {cp_b_i, 2'b11};

  always_comb begin
    word_o = '0;
    if (res_en_i) begin
      unique case (ptr_i)
        2'd0:    word_o = {lp_a_i[15:8], lp_a_i[7:0]};
        2'd1:    word_o = {lp_b_i[7:0], cb_a};
        2'd2:    word_o = {cb_b, lp_b_i[15:8]};
        default: word_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/page_ecc_gen.sv
module page_ecc_gen
  import pecc_pkg::*;
#(
  parameter int HALF_BYTES = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_wr_i,
  input  logic [7:0]  mode_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        rd_i,
  output logic [15:0] rd_data_o
);
  localparam int IDX_W  = $clog2(HALF_BYTES);
  localparam int LP_W   = 2 * IDX_W;
  localparam int NHALF  = 2;

  logic [BYTE_W-1:0] mode_q;
  logic              clr, take, half;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W+1:0]  byte_cnt;
  logic [PTR_W-1:0]  rd_ptr;
  logic [LP_W-1:0]   lp [NHALF];
  logic [CP_W-1:0]   cp [NHALF];

  ecc_mode_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wr_i  (mode_wr_i),
    .mode_i     (mode_i),
    .byte_vld_i (byte_vld_i),
    .rd_i       (rd_i),
    .mode_q_o   (mode_q),
    .clr_o      (clr),
    .take_o     (take),
    .idx_o      (idx),
    .half_o     (half),
    .cnt_o      (byte_cnt),
    .ptr_o      (rd_ptr)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic take_h;
    assign take_h = take && (half == 1'(h));
    ecc_half_acc #(.IDX_W(IDX_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .take_i (take_h),
      .idx_i  (idx),
      .data_i (byte_i),
      .lp_o   (lp[h]),
      .cp_o   (cp[h])
    );
  end

  ecc_result_mux u_mux (
    .lp_a_i   (lp[0][15:0]),
    .cp_a_i   (cp[0]),
    .lp_b_i   (lp[1][15:0]),
    .cp_b_i   (cp[1]),
    .ptr_i    (rd_ptr),
    .res_en_i (mode_q == MODE_RES),
    .word_o   (rd_data_o)
  );
endmodule

// File: rtl/ecc_gen_chk.sv
module ecc_gen_chk
  import pecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_wr_i,
  input logic [7:0]        mode_i,
  input logic              byte_vld_i,
  input logic              rd_i,
  input logic [15:0]       rd_data_o,
  input logic [7:0]        mode_q,
  input logic [IDX_W+1:0]  byte_cnt,
  input logic [PTR_W-1:0]  rd_ptr
);
  localparam logic [IDX_W+1:0] PAGE_LIM = {2'b10, {IDX_W{1'b0}}};

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && mode_i == MODE_CLR) |=> (byte_cnt == '0)); // R2

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(mode_q == MODE_CALC && byte_vld_i) && !(mode_wr_i && mode_i == MODE_CLR))
      |=> $stable(byte_cnt)); // R3

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt <= PAGE_LIM); // R4

  AST_OUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_RES) |-> (rd_data_o == 16'h0000)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RES && !rd_i && !mode_wr_i) |=> $stable(rd_data_o)); // R8

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ptr < PTR_W'(NWORDS)); // R9

  AST_PTR_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (rd_ptr == '0)); // R9
endmodule

bind page_ecc_gen ecc_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_wr_i  (mode_wr_i),
  .mode_i     (mode_i),
  .byte_vld_i (byte_vld_i),
  .rd_i       (rd_i),
  .rd_data_o  (rd_data_o),
  .mode_q     (mode_q),
  .byte_cnt   (byte_cnt),
  .rd_ptr     (rd_ptr)
);

// File: tb/tb_page_ecc_gen.sv
module tb_page_ecc_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        mode_wr_i, byte_vld_i, rd_i;
  logic [7:0]  mode_i, byte_i;
  logic [15:0] rd_data_o;

  localparam logic [7:0] M_IDLE = 8'h00, M_CLR = 8'hF4, M_CALC = 8'hB4, M_RES = 8'hD4;

  int    n_chk = 0, n_fail = 0, n_cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [7:0] qa[$], qb[$];
  logic [7:0] m_mode;
  int         m_cnt, m_ptr;

  always #4 clk_i = ~clk_i;

  page_ecc_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .rd_i(rd_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [21:0] half_ecc(input logic [7:0] q[$]);
    logic [15:0] lp;
    logic [5:0]  cp;
    lp = '0;
    cp = '0;
    for (int i = 0; i < q.size(); i++) begin
      logic p;
      p = ^q[i];
      for (int k = 0; k < 8; k++)
        if (((i >> k) & 1) != 0) lp[2*k+1] ^= p; else lp[2*k] ^= p;
      for (int j = 0; j < 8; j++)
        if (q[i][j])
          for (int k = 0; k < 3; k++)
            if (((j >> k) & 1) != 0) cp[2*k+1] ^= 1'b1; else cp[2*k] ^= 1'b1;
    end
    return {~cp, ~lp};
  endfunction

  function automatic logic [15:0] model_word(input int w);
    logic [21:0] ea, eb;
    logic [7:0]  ca, cb;
    ea = half_ecc(qa);
    eb = half_ecc(qb);
    ca = {ea[21:16], 2'b11};
    cb = {eb[21:16], 2'b11};
    case (w)
      0: return ea[15:0];
      1: return {eb[7:0], ca};
      default: return {cb, eb[15:8]};
    endcase
  endfunction

  function automatic logic [15:0] model_out();
    return (m_mode == M_RES) ? model_word(m_ptr) : 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic mw, input logic [7:0] mv, input logic bv,
                            input logic [7:0] bd, input logic rd);
    if (bv && m_mode == M_CALC && m_cnt < 512) begin
      if (m_cnt < 256) qa.push_back(bd); else qb.push_back(bd);
      m_cnt++;
    end
    if (rd && m_mode == M_RES) m_ptr = (m_ptr == 2) ? 0 : m_ptr + 1;
    if (mw) begin
      if (mv == M_CLR) begin
        qa.delete();
        qb.delete();
        m_cnt = 0;
      end
      m_ptr  = 0;
      m_mode = mv;
    end
  endtask

  task automatic cyc(input logic mw, input logic [7:0] mv, input logic bv,
                     input logic [7:0] bd, input logic rd);
    mode_wr_i = mw; mode_i = mv; byte_vld_i = bv; byte_i = bd; rd_i = rd;
    @(posedge clk_i);
    model_step(mw, mv, bv, bd, rd);
    @(negedge clk_i);
    mode_wr_i = 1'b0; byte_vld_i = 1'b0; rd_i = 1'b0;
    check(cur_req, rd_data_o, model_out());
  endtask

  task automatic set_mode(input logic [7:0] v);
    cyc(1'b1, v, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic put(input logic [7:0] b);
    cyc(1'b0, 8'h00, 1'b1, b, 1'b0);
  endtask

  task automatic read_word(input string req, input logic [15:0] exp);
    check(req, rd_data_o, exp);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
  endtask

  task automatic start_page();
    set_mode(M_CLR);
    cyc(1'b0, 8'h00, 1'b1, 8'h5A, 1'b1);   // dummy read plus stray byte (R2)
    set_mode(M_CALC);
  endtask

  always @(posedge clk_i) begin
    n_cyc++;
    if (n_cyc > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", n_cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; mode_wr_i = 1'b0; mode_i = 8'h00; byte_vld_i = 1'b0;
    byte_i = 8'h00; rd_i = 1'b0;
    m_mode = M_IDLE; m_cnt = 0; m_ptr = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 reset output", rd_data_o, 16'h0000);
    set_mode(M_RES);
    check("R1 cleared sets word0", rd_data_o, 16'hFFFF);

    // R7 erased page
    cur_req = "R7";
    start_page();
    for (int i = 0; i < 512; i++) put(8'hFF);
    set_mode(M_RES);
    read_word("R7 erased w0", 16'hFFFF);
    read_word("R7 erased w1", 16'hFFFF);
    read_word("R7 erased w2", 16'hFFFF);

    // R5 R6 R8 single-bit vectors: A[0]=01, B[255]=80
    cur_req = "R5";
    start_page();
    put(8'h01);
    for (int i = 1; i < 511; i++) put(8'h00);
    put(8'h80);
    set_mode(M_RES);
    read_word("R5 R8 w0", 16'hAAAA);
    read_word("R6 R8 w1", 16'h55AB);
    read_word("R6 R8 w2", 16'h5755);
    check("R9 wrap to w0", rd_data_o, 16'hAAAA);

    // R9 pointer returns on mode write
    cur_req = "R9";
    read_word("R9 w0 again", 16'hAAAA);
    set_mode(M_IDLE);
    check("R8 quiet outside result", rd_data_o, 16'h0000);
    set_mode(M_RES);
    check("R9 restart at w0", rd_data_o, 16'hAAAA);
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    cyc(1'b1, M_RES, 1'b0, 8'h00, 1'b1);   // read collides with mode write (R10)
    check("R10 R9 read vs mode write", rd_data_o, 16'hAAAA);

    // R3 bytes outside calc ignored
    cur_req = "R3";
    cyc(1'b0, 8'h00, 1'b1, 8'h01, 1'b0);
    set_mode(M_IDLE);
    put(8'h37);
    set_mode(M_RES);
    check("R3 ignored outside calc", rd_data_o, 16'hAAAA);

    // R4 random page then overflow bytes
    cur_req = "R4";
    start_page();
    for (int i = 0; i < 512; i++) put(8'($urandom_range(0, 255)));
    set_mode(M_RES);
    begin
      logic [15:0] w0, w1, w2;
      w0 = model_word(0); w1 = model_word(1); w2 = model_word(2);
      check("R5 random page w0", rd_data_o, w0);
      set_mode(M_CALC);
      for (int i = 0; i < 4; i++) put(8'hC3);
      set_mode(M_RES);
      read_word("R4 beyond 512 w0", w0);
      read_word("R4 beyond 512 w1", w1);
      read_word("R4 beyond 512 w2", w2);
    end

    // R4 half split: only set B touched
    start_page();
    for (int i = 0; i < 256; i++) put(8'h00);
    put(8'h01);
    set_mode(M_RES);
    read_word("R4 split w0", 16'hFFFF);
    read_word("R4 split w1", 16'hAAFF);

    // R10 collisions
    cur_req = "R10";
    set_mode(M_CALC);
    cyc(1'b1, M_CLR, 1'b1, 8'h01, 1'b0);   // clear wins
    cyc(1'b1, M_CALC, 1'b1, 8'h01, 1'b0);  // judged under clear mode
    set_mode(M_RES);
    read_word("R10 collision w0", 16'hFFFF);
    read_word("R10 collision w1", 16'hFFFF);
    read_word("R10 collision w2", 16'hFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule